// File: doc/BRIEF.md
# Ping-pong command buffer manager

This block decides which of two input command buffers a command interpreter reads from. An external producer fills the buffers and raises one ready flag per buffer in a 4-bit buffer status word. The block keeps track of the buffer in use. It holds the interpreter idle until that buffer's ready flag is set, then publishes the read base address and starts the interpreter.

When the interpreter reaches an end-of-buffer command, it pulses `switch_req`. The block then does three things. It writes a completion indicator for the buffer just finished to a fixed location. It acknowledges that buffer to the producer with a one-cycle code. It selects the other buffer and waits for that buffer's ready flag.

Each time a wait ends, the observed status word is copied to a shared status location. A pointer-load strobe tells the interpreter to reload its read pointer from `rd_base` and to rewind its result pointer to the output base. Buffer memory is outside this block.

Top module: `pingpong_cmd_mgr`

## Requirements
- R1: After reset, `cmd_run` is low, `rd_base` equals `BUF0_BASE` (buffer 0 is selected), `ack_code` is 0 and `st_we` is low.
- R2: While waiting, the block stays idle (`cmd_run` low, no write, no `ptr_load`) until the ready bit of the selected buffer is set. Bit 2 of `buf_status` is the ready bit for buffer 0 and bit 3 is the ready bit for buffer 1. The other buffer's ready bit has no effect.
- R3: In a cycle in which the block is waiting and the selected ready bit is 1, `st_we` is 1, `st_addr` equals `STATUS_ADDR`, `st_wdata` equals `buf_status` zero-extended, and `ptr_load` is 1. In the next cycle `cmd_run` is 1, and neither write nor `ptr_load` repeats.
- R4: After a clock edge at which `cmd_run` and `switch_req` are both 1, `cmd_run` is 0 and `ack_code` holds the code of the buffer just consumed for exactly one cycle. The code is 1 for buffer 0 and 2 for buffer 1. After that cycle `ack_code` returns to 0.
- R5: In the same cycle as the acknowledge, `st_we` is 1, `st_addr` equals `FLAG_ADDR`, and `st_wdata` is 8'h01 if the finished buffer was buffer 0 or 8'h03 if it was buffer 1. Bit 0 is set in both cases.
- R6: In the cycle after the acknowledge, `rd_base` shows the base of the other buffer (`BUF1_BASE` after buffer 0, `BUF0_BASE` after buffer 1), and the block waits on that buffer's ready bit.
- R7: `switch_req` has no effect while `cmd_run` is low. It causes no acknowledge, no flag write and no change of `rd_base`.
- R8: The first start after reset produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_status | input | 4 | Producer status word. Bit 2 means buffer 0 is ready, bit 3 means buffer 1 is ready. |
| switch_req | input | 1 | End-of-buffer command from the interpreter |
| ack_code | output | 2 | One-cycle acknowledge code: 1 for buffer 0, 2 for buffer 1, otherwise 0 |
| rd_base | output | AW | Base address of the selected input buffer |
| ptr_load | output | 1 | Strobe telling the interpreter to load its read pointer and rewind its result pointer |
| cmd_run | output | 1 | Interpreter may execute commands |
| st_we | output | 1 | Status/flag write enable |
| st_addr | output | AW | Status/flag write address |
| st_wdata | output | 8 | Status/flag write data |

## Verification
If the stored buffer selection were wrong, the error would appear at the first switch. `ack_code` would carry the wrong code, the completion flag would carry the wrong value, and on the following cycle `rd_base` would point at the wrong buffer. If the sequencing state were wrong, the block might run while its buffer is not ready, stay stuck waiting, or repeat the acknowledge. Each of these faults shows up on `cmd_run`, `st_we` or `ack_code` within one or two cycles of the triggering edge.

// File: rtl/pingpong_cmd_mgr.sv
module pingpong_cmd_mgr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BUF0_BASE   = 16'h0100,
  parameter logic [AW-1:0] BUF1_BASE   = 16'h0300,
  parameter logic [AW-1:0] FLAG_ADDR   = 16'h0FF0,
  parameter logic [AW-1:0] STATUS_ADDR = 16'h0FF1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    buf_status,
  input  logic          switch_req,
  output logic [1:0]    ack_code,
  output logic [AW-1:0] rd_base,
  output logic          ptr_load,
  output logic          cmd_run,
  output logic          st_we,
  output logic [AW-1:0] st_addr,
  output logic [7:0]    st_wdata
);

  typedef enum logic [1:0] {S_WAIT, S_RUN, S_SWITCH} state_t;

  state_t state;
  logic   sel;
  logic   sel_rdy;

  assign sel_rdy  = buf_status[{1'b1, sel}];
  assign cmd_run  = (state == S_RUN);
  assign ptr_load = (state == S_WAIT) && sel_rdy;
  assign rd_base  = sel ? BUF1_BASE : BUF0_BASE;
  assign ack_code = (state == S_SWITCH) ? (sel ? 2'd2 : 2'd1) : 2'd0;
  assign st_we    = ptr_load || (state == S_SWITCH);
  assign st_addr  = (state == S_SWITCH) ? FLAG_ADDR : STATUS_ADDR;
  assign st_wdata = (state == S_SWITCH) ? {6'd0, sel, 1'b1} : {4'd0, buf_status};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_WAIT;
      sel   <= 1'b0;
    end else begin
      case (state)
        S_WAIT:   if (sel_rdy) state <= S_RUN;
        S_RUN:    if (switch_req) state <= S_SWITCH;
        default: begin
          state <= S_WAIT;
          sel   <= ~sel;
        end
      endcase
    end
  end

  a_r3_run_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> cmd_run && !ptr_load);
  a_r4_switch_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_run && switch_req) |=> (ack_code != 2'd0) && !cmd_run);
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_code != 2'd0) |=> (ack_code == 2'd0));
  a_r5_flag_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_addr == FLAG_ADDR) |-> st_wdata[0]);
  a_r6_to_buf1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_code == 2'd1) |=> (rd_base == BUF1_BASE));
  a_r6_to_buf0: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_code == 2'd2) |=> (rd_base == BUF0_BASE));
  a_r7_idle_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_run && switch_req) |=> (ack_code == 2'd0));

endmodule

// File: tb/test_pingpong_cmd_mgr.sv
module test_pingpong_cmd_mgr;
  localparam int AW = 16;
  localparam logic [AW-1:0] B0 = 16'h0100, B1 = 16'h0300;
  localparam logic [AW-1:0] FA = 16'h0FF0, SA = 16'h0FF1;

  logic clk = 1'b0, rst_n = 1'b0, switch_req = 1'b0;
  logic [3:0] buf_status = 4'd0;
  logic [1:0] ack_code;
  logic [AW-1:0] rd_base, st_addr;
  logic ptr_load, cmd_run, st_we;
  logic [7:0] st_wdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pingpong_cmd_mgr #(.AW(AW), .BUF0_BASE(B0), .BUF1_BASE(B1),
    .FLAG_ADDR(FA), .STATUS_ADDR(SA)) i_pingpong_cmd_mgr (
    .clk(clk), .rst_n(rst_n), .buf_status(buf_status), .switch_req(switch_req),
    .ack_code(ack_code), .rd_base(rd_base), .ptr_load(ptr_load), .cmd_run(cmd_run),
    .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; #0.5;
    chk("R1 run", cmd_run, 0);
    chk("R1 rd_base", rd_base, B0);
    chk("R1 ack", ack_code, 0);
    chk("R1 we", st_we, 0);
  endtask

  task automatic t_wait(input logic [3:0] other, input logic [3:0] go, input logic [AW-1:0] base);
    buf_status = other; step(); step(); #0.5;
    chk("R2 idle run", cmd_run, 0);
    chk("R2 idle we", st_we, 0);
    chk("R2 idle load", ptr_load, 0);
    buf_status = go; #0.5;
    chk("R3 we", st_we, 1);
    chk("R3 addr", st_addr, SA);
    chk("R3 data", st_wdata, {4'd0, go});
    chk("R3 load", ptr_load, 1);
    chk("R8 no ack at start", ack_code, 0);
    chk("R6 base held", rd_base, base);
    step();
    chk("R3 run", cmd_run, 1);
    chk("R3 single we", st_we, 0);
    chk("R3 single load", ptr_load, 0);
    buf_status = 4'd0;
  endtask

  task automatic t_switch(input logic [1:0] code, input logic [7:0] flag, input logic [AW-1:0] nbase);
    step();
    chk("R4 still run", cmd_run, 1);
    switch_req = 1'b1; step(); switch_req = 1'b0; #0.5;
    chk("R4 ack", ack_code, code);
    chk("R4 run low", cmd_run, 0);
    chk("R5 we", st_we, 1);
    chk("R5 addr", st_addr, FA);
    chk("R5 flag", st_wdata, flag);
    step();
    chk("R4 ack clear", ack_code, 0);
    chk("R6 new base", rd_base, nbase);
    chk("R6 waiting", cmd_run, 0);
    chk("R6 no we", st_we, 0);
  endtask

  task automatic t_ignore();
    switch_req = 1'b1; step(); step(); #0.5;
    chk("R7 no ack", ack_code, 0);
    chk("R7 no we", st_we, 0);
    chk("R7 base", rd_base, B1);
    chk("R7 run", cmd_run, 0);
    switch_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_wait(4'b1000, 4'b0100, B0);
    t_switch(2'd1, 8'h01, B1);
    t_ignore();
    t_wait(4'b0100, 4'b1100, B1);
    t_switch(2'd2, 8'h03, B0);
    t_wait(4'b1011, 4'b0111, B0);
    t_switch(2'd1, 8'h01, B1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule